// File: doc/BRIEF.md
# I2C Master Counted-Transfer Sequencer

This block drives a byte-level I2C master engine through a whole transaction without processor help. Software performs one write to an address word. That word carries a 7-bit target address, a direction bit, an 8-bit byte count and a count-enable bit. The sequencer then starts the address phase. It moves each data byte through a DMA request pair, one request for bytes to send and one for bytes received. It counts the bytes. On the final byte of a read it tells the engine to NACK, and when the count is used up it ends the transfer with a STOP.

A write that the slave refuses before the final byte is cut short with an immediate STOP. This sets a sticky length-error status and the error interrupt flag. A refused address phase also ends with a STOP and raises the error flag, but it leaves the length-error status clear. Bit timing, arbitration and clock stretching stay inside the engine. The sequencer only sees a command/done handshake.

Top module: `i2c_len_seq`

## Requirements
- R1: After reset the sequencer is idle (`busy`=0). No command is offered (`engCmdValid`=0, `engCmd`=0). Both DMA requests and all three flags (`irqBusOwn`, `irqError`, `lenErr`) are 0.
- R2: An address write with `addrLenEn`=1 while idle offers a START command (`engCmd`=1). It drives `engTxByte` = {`addrSlave`, `addrRead`}. An address write with `addrLenEn`=0 is ignored: no command is offered and `busy` stays 0.
- R3: While `smartEn`=0 neither DMA request is asserted, even when a byte is pending. Setting `smartEn` shows the pending request in the same cycle.
- R4: In a write, `dmaTxReq` rises when the next byte is needed. It is low in the cycle after a `dataWr` pulse. The WRITE command (`engCmd`=2) that follows presents the written byte on `engTxByte`.
- R5: In a read, `dmaRxReq` rises after each received byte, with that byte on `dataRdByte`. It is low in the cycle after a `dataRd` pulse.
- R6: With a count N>0, exactly N data commands are issued. In a read the first N-1 are READ with ACK (`engCmd`=3) and the last is READ with NACK (`engCmd`=4). A single STOP (`engCmd`=5) follows.
- R7: A count of 0 runs the address phase and then STOP, with no data command and no DMA request.
- R8: A slave NACK on a write byte other than the last issues STOP next. It sets `lenErr` and `irqError`. A NACK on the last byte sets neither.
- R9: A NACK on the address phase issues STOP next and sets `irqError`. It leaves `lenErr` and `irqBusOwn` clear and sends no data.
- R10: An acknowledged address phase sets `irqBusOwn`.
- R11: Each flag stays set until a `flagClr` pulse with a 1 in its mask bit: bit 0 clears `irqBusOwn`, bit 1 clears `irqError`, bit 2 clears `lenErr`. Flags whose mask bit is 0 are kept.
- R12: `dmaRxReq` and `dmaTxReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| smartEn | input | 1 | Enables the DMA request outputs |
| addrWr | input | 1 | Address-word write strobe |
| addrSlave | input | 7 | Target address |
| addrRead | input | 1 | 1 = read transaction |
| addrLen | input | 8 | Data byte count |
| addrLenEn | input | 1 | Count-enable; a write with this clear is ignored |
| dataWr | input | 1 | Data register write strobe (DMA TX service) |
| dataWrByte | input | 8 | Byte to send |
| dataRd | input | 1 | Data register read strobe (DMA RX service) |
| dataRdByte | output | 8 | Last received byte |
| flagClr | input | 1 | Flag clear strobe |
| flagClrMask | input | 3 | Write-1-to-clear mask: bit0 bus-own, bit1 error, bit2 length error |
| engCmdValid | output | 1 | Command offered to the byte engine |
| engCmd | output | 3 | 0 none, 1 START+address, 2 WRITE, 3 READ+ACK, 4 READ+NACK, 5 STOP |
| engTxByte | output | 8 | Address byte or data byte for the engine |
| engDone | input | 1 | Engine finished the offered command |
| engAck | input | 1 | Slave ACK seen for START/WRITE, valid with engDone |
| engRxByte | input | 8 | Byte received by a READ, valid with engDone |
| dmaRxReq | output | 1 | Received byte waiting to be read |
| dmaTxReq | output | 1 | Byte to send is needed |
| irqBusOwn | output | 1 | Master-on-bus flag |
| irqError | output | 1 | Error flag |
| lenErr | output | 1 | Length-error status |
| busy | output | 1 | Transaction in progress |

## Verification
The state register is the only stage between a stimulus and the outputs. A command, a DMA request and a flag therefore appear one clock after the pulse that causes them (`addrWr`, `engDone`, `dataWr`, `dataRd`, `flagClr`). The only exception is the `smartEn` gating, which acts in the same cycle. The bench drives every pulse just after a falling edge and samples at the next falling edge, half a period after the rising edge that acted on it. From that sample it decides the next response of its engine model, so every check reads the value that is due in that exact cycle.

// File: rtl/i2c_len_seq_pkg.sv
package i2c_len_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_START     = 3'd1,
    CMD_WRITE     = 3'd2,
    CMD_READ_ACK  = 3'd3,
    CMD_READ_NACK = 3'd4,
    CMD_STOP      = 3'd5
  } engCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT_TX,
    ST_SEND,
    ST_RECV,
    ST_WAIT_RX,
    ST_STOP
  } seqState_t;

  typedef struct packed {
    logic load;
    logic dec;
    logic latchTx;
    logic latchRx;
    logic setBus;
    logic setErr;
    logic setLenErr;
    logic selAddr;
  } seqStb_t;

endpackage

// File: rtl/i2c_len_seq_ctrl.sv
module i2c_len_seq_ctrl
  import i2c_len_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    isRead,
  input  logic    cntZero,
  input  logic    cntOne,
  input  logic    dataWr,
  input  logic    dataRd,
  input  logic    engDone,
  input  logic    engAck,
  output logic    cmdValid,
  output engCmd_t cmd,
  output logic    txNeed,
  output logic    rxReady,
  output logic    busy,
  output seqStb_t stb
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    stb      = '0;
    cmdValid = 1'b0;
    cmd      = CMD_NONE;
    txNeed   = 1'b0;
    rxReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.load = 1'b1;
          nxt      = ST_ADDR;
        end
      end
      ST_ADDR: begin
        cmdValid    = 1'b1;
        cmd         = CMD_START;
        stb.selAddr = 1'b1;
        if (engDone) begin
          if (!engAck) begin
            stb.setErr = 1'b1;
            nxt        = ST_STOP;
          end else begin
            stb.setBus = 1'b1;
            if (cntZero)     nxt = ST_STOP;
            else if (isRead) nxt = ST_RECV;
            else             nxt = ST_WAIT_TX;
          end
        end
      end
      ST_WAIT_TX: begin
        txNeed = 1'b1;
        if (dataWr) begin
          stb.latchTx = 1'b1;
          nxt         = ST_SEND;
        end
      end
      ST_SEND: begin
        cmdValid = 1'b1;
        cmd      = CMD_WRITE;
        if (engDone) begin
          stb.dec = 1'b1;
          if (cntOne) begin
            nxt = ST_STOP;
          end else if (!engAck) begin
            stb.setErr    = 1'b1;
            stb.setLenErr = 1'b1;
            nxt           = ST_STOP;
          end else begin
            nxt = ST_WAIT_TX;
          end
        end
      end
      ST_RECV: begin
        cmdValid = 1'b1;
        cmd      = cntOne ? CMD_READ_NACK : CMD_READ_ACK;
        if (engDone) begin
          stb.latchRx = 1'b1;
          stb.dec     = 1'b1;
          nxt         = ST_WAIT_RX;
        end
      end
      ST_WAIT_RX: begin
        rxReady = 1'b1;
        if (dataRd) nxt = cntZero ? ST_STOP : ST_RECV;
      end
      ST_STOP: begin
        cmdValid = 1'b1;
        cmd      = CMD_STOP;
        if (engDone) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/i2c_len_seq_dp.sv
module i2c_len_seq_dp
  import i2c_len_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [ADDR_W-1:0] addrSlave,
  input  logic              addrRead,
  input  logic [LEN_W-1:0]  addrLen,
  input  logic [DATA_W-1:0] dataWrByte,
  input  logic [DATA_W-1:0] engRxByte,
  input  logic              flagClr,
  input  logic [2:0]        flagClrMask,
  output logic              cntZero,
  output logic              cntOne,
  output logic              isRead,
  output logic [DATA_W-1:0] engTxByte,
  output logic [DATA_W-1:0] dataRdByte,
  output logic              flagBus,
  output logic              flagErr,
  output logic              flagLenErr
);

  localparam int ADDR_BYTE_W = ADDR_W + 1;

  logic [LEN_W-1:0]       cnt;
  logic [ADDR_BYTE_W-1:0] addrByte;
  logic [DATA_W-1:0]      txByte;
  logic [DATA_W-1:0]      rxByte;
  logic [2:0]             clrBits;

  assign clrBits = flagClr ? flagClrMask : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      addrByte <= '0;
      isRead   <= 1'b0;
      txByte   <= '0;
      rxByte   <= '0;
    end else begin
      if (stb.load) begin
        cnt      <= addrLen;
        addrByte <= {addrSlave, addrRead};
        isRead   <= addrRead;
      end else if (stb.dec) begin
        cnt <= cnt - 1'b1;
      end
      if (stb.latchTx) txByte <= dataWrByte;
      if (stb.latchRx) rxByte <= engRxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagBus    <= 1'b0;
      flagErr    <= 1'b0;
      flagLenErr <= 1'b0;
    end else begin
      flagBus    <= stb.setBus    | (flagBus    & ~clrBits[0]);
      flagErr    <= stb.setErr    | (flagErr    & ~clrBits[1]);
      flagLenErr <= stb.setLenErr | (flagLenErr & ~clrBits[2]);
    end
  end

  assign cntZero    = (cnt == '0);
  assign cntOne     = (cnt == LEN_W'(1));
  assign engTxByte  = stb.selAddr ? DATA_W'(addrByte) : txByte;
  assign dataRdByte = rxByte;

endmodule

// File: rtl/i2c_len_seq.sv
module i2c_len_seq
  import i2c_len_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smartEn,
  input  logic              addrWr,
  input  logic [ADDR_W-1:0] addrSlave,
  input  logic              addrRead,
  input  logic [LEN_W-1:0]  addrLen,
  input  logic              addrLenEn,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataWrByte,
  input  logic              dataRd,
  output logic [DATA_W-1:0] dataRdByte,
  input  logic              flagClr,
  input  logic [2:0]        flagClrMask,
  output logic              engCmdValid,
  output logic [2:0]        engCmd,
  output logic [DATA_W-1:0] engTxByte,
  input  logic              engDone,
  input  logic              engAck,
  input  logic [DATA_W-1:0] engRxByte,
  output logic              dmaRxReq,
  output logic              dmaTxReq,
  output logic              irqBusOwn,
  output logic              irqError,
  output logic              lenErr,
  output logic              busy
);

  seqStb_t stb;
  engCmd_t cmd;
  logic    cntZero, cntOne, isRead, txNeed, rxReady;

  i2c_len_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (addrWr & addrLenEn),
    .isRead   (isRead),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .dataWr   (dataWr),
    .dataRd   (dataRd),
    .engDone  (engDone),
    .engAck   (engAck),
    .cmdValid (engCmdValid),
    .cmd      (cmd),
    .txNeed   (txNeed),
    .rxReady  (rxReady),
    .busy     (busy),
    .stb      (stb)
  );

  i2c_len_seq_dp #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .addrSlave   (addrSlave),
    .addrRead    (addrRead),
    .addrLen     (addrLen),
    .dataWrByte  (dataWrByte),
    .engRxByte   (engRxByte),
    .flagClr     (flagClr),
    .flagClrMask (flagClrMask),
    .cntZero     (cntZero),
    .cntOne      (cntOne),
    .isRead      (isRead),
    .engTxByte   (engTxByte),
    .dataRdByte  (dataRdByte),
    .flagBus     (irqBusOwn),
    .flagErr     (irqError),
    .flagLenErr  (lenErr)
  );

  assign engCmd   = cmd;
  assign dmaTxReq = smartEn & txNeed;
  assign dmaRxReq = smartEn & rxReady;

endmodule

// File: rtl/i2c_len_seq_chk.sv
module i2c_len_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       smartEn,
  input logic       dataWr,
  input logic       dataRd,
  input logic       flagClr,
  input logic [2:0] flagClrMask,
  input logic       engDone,
  input logic       engAck,
  input logic [2:0] engCmd,
  input logic       dmaRxReq,
  input logic       dmaTxReq,
  input logic       irqError,
  input logic       irqBusOwn,
  input logic       lenErr
);

  a_r12_one_req: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaRxReq && dmaTxReq));

  a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
    !smartEn |-> (!dmaRxReq && !dmaTxReq));

  a_r4_tx_drop: assert property (@(posedge clk) disable iff (!rstN)
    (dmaTxReq && dataWr) |=> !dmaTxReq);

  a_r5_rx_drop: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRxReq && dataRd) |=> !dmaRxReq);

  a_r8_lenerr_has_err: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenErr) |-> irqError);

  a_r8_early_nack_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenErr) |-> (engCmd == 3'd5));

  a_r9_addr_nack: assert property (@(posedge clk) disable iff (!rstN)
    (engCmd == 3'd1 && engDone && !engAck) |=> (engCmd == 3'd5));

  a_r11_lenerr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lenErr && !(flagClr && flagClrMask[2])) |=> lenErr);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqError && !(flagClr && flagClrMask[1])) |=> irqError);

  a_r11_bus_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqBusOwn && !(flagClr && flagClrMask[0])) |=> irqBusOwn);

endmodule

bind i2c_len_seq i2c_len_seq_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .smartEn     (smartEn),
  .dataWr      (dataWr),
  .dataRd      (dataRd),
  .flagClr     (flagClr),
  .flagClrMask (flagClrMask),
  .engDone     (engDone),
  .engAck      (engAck),
  .engCmd      (engCmd),
  .dmaRxReq    (dmaRxReq),
  .dmaTxReq    (dmaTxReq),
  .irqError    (irqError),
  .irqBusOwn   (irqBusOwn),
  .lenErr      (lenErr)
);

// File: tb/i2c_len_seq_tb.sv
module i2c_len_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       smartEn = 1'b1;
  logic       addrWr = 1'b0;
  logic [6:0] addrSlave = '0;
  logic       addrRead = 1'b0;
  logic [7:0] addrLen = '0;
  logic       addrLenEn = 1'b0;
  logic       dataWr = 1'b0;
  logic [7:0] dataWrByte = '0;
  logic       dataRd = 1'b0;
  logic [7:0] dataRdByte;
  logic       flagClr = 1'b0;
  logic [2:0] flagClrMask = '0;
  logic       engCmdValid;
  logic [2:0] engCmd;
  logic [7:0] engTxByte;
  logic       engDone = 1'b0;
  logic       engAck = 1'b0;
  logic [7:0] engRxByte = '0;
  logic       dmaRxReq, dmaTxReq, irqBusOwn, irqError, lenErr, busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_len_seq dut_i (
    .clk(clk), .rstN(rstN), .smartEn(smartEn), .addrWr(addrWr),
    .addrSlave(addrSlave), .addrRead(addrRead), .addrLen(addrLen),
    .addrLenEn(addrLenEn), .dataWr(dataWr), .dataWrByte(dataWrByte),
    .dataRd(dataRd), .dataRdByte(dataRdByte), .flagClr(flagClr),
    .flagClrMask(flagClrMask), .engCmdValid(engCmdValid), .engCmd(engCmd),
    .engTxByte(engTxByte), .engDone(engDone), .engAck(engAck),
    .engRxByte(engRxByte), .dmaRxReq(dmaRxReq), .dmaTxReq(dmaTxReq),
    .irqBusOwn(irqBusOwn), .irqError(irqError), .lenErr(lenErr), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    addrWr = 1'b0; dataWr = 1'b0; dataRd = 1'b0; flagClr = 1'b0; engDone = 1'b0;
  endtask

  // transaction results collected by runTxn
  int nStart, nWr, nRdAck, nRdNack, nStop;
  bit bothSeen, dropBad, byteBad, addrBad, timedOut;

  // vector: {read, addrNack, len[7:0], nackAt[7:0]} ; nackAt 255 = never
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd3,   8'd255},
    {1'b1, 1'b0, 8'd3,   8'd255},
    {1'b0, 1'b0, 8'd0,   8'd255},
    {1'b1, 1'b0, 8'd1,   8'd255},
    {1'b0, 1'b0, 8'd4,   8'd1},
    {1'b0, 1'b0, 8'd2,   8'd1},
    {1'b0, 1'b1, 8'd2,   8'd255},
    {1'b1, 1'b0, 8'd255, 8'd255}
  };

  task automatic runTxn(input bit rd, input bit aNack, input int len, input int nackAt);
    int wrIdx = 0;
    int rdIdx = 0;
    bit prevTx = 0;
    bit prevRx = 0;
    bit stopSeen = 0;
    logic [7:0] lastWr = '0;
    nStart = 0; nWr = 0; nRdAck = 0; nRdNack = 0; nStop = 0;
    bothSeen = 0; dropBad = 0; byteBad = 0; addrBad = 0; timedOut = 1;
    step();
    flagClr = 1'b1; flagClrMask = 3'b111;
    step();
    addrWr = 1'b1; addrSlave = 7'h5A; addrRead = rd; addrLen = 8'(len); addrLenEn = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      step();
      if (stopSeen && !busy) begin timedOut = 0; break; end
      if (dmaTxReq && dmaRxReq) bothSeen = 1;
      if (prevTx && dmaTxReq) dropBad = 1;
      if (prevRx && dmaRxReq) dropBad = 1;
      prevTx = 0; prevRx = 0;
      if (dmaTxReq) begin
        lastWr = 8'h30 + 8'(wrIdx);
        dataWrByte = lastWr; dataWr = 1'b1; prevTx = 1; wrIdx++;
      end
      if (dmaRxReq) begin
        if (dataRdByte != 8'hA0 + 8'(rdIdx - 1)) byteBad = 1;
        dataRd = 1'b1; prevRx = 1;
      end
      if (engCmdValid) begin
        engDone = 1'b1;
        case (engCmd)
          3'd1: begin
            nStart++;
            if (engTxByte != {7'h5A, rd}) addrBad = 1;
            engAck = !aNack;
          end
          3'd2: begin
            if (engTxByte != lastWr) byteBad = 1;
            engAck = (nWr != nackAt);
            nWr++;
          end
          3'd3, 3'd4: begin
            if (engCmd == 3'd3) nRdAck++; else nRdNack++;
            engRxByte = 8'hA0 + 8'(rdIdx); rdIdx++;
          end
          default: begin nStop++; stopSeen = 1; engAck = 1'b1; end
        endcase
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1 reset state
    check(!busy && !engCmdValid && engCmd == 3'd0, "R1 idle", int'(busy), 0);
    check(!dmaRxReq && !dmaTxReq, "R1 requests", int'({dmaRxReq, dmaTxReq}), 0);
    check(!irqBusOwn && !irqError && !lenErr, "R1 flags",
          int'({irqBusOwn, irqError, lenErr}), 0);

    // table-driven transactions
    for (int v = 0; v < NV; v++) begin
      bit rd = VEC[v][17];
      bit an = VEC[v][16];
      int len = int'(VEC[v][15:8]);
      int nk = int'(VEC[v][7:0]);
      int expWr, expRdAck, expRdNack;
      bit expLenErr;
      expWr     = (an || rd) ? 0 : ((nk < len) ? nk + 1 : len);
      expRdAck  = (an || !rd || len == 0) ? 0 : len - 1;
      expRdNack = (an || !rd || len == 0) ? 0 : 1;
      expLenErr = !an && !rd && (nk < len - 1);
      runTxn(rd, an, len, nk);
      check(!timedOut, "R6 transaction ends", int'(timedOut), 0);
      check(nStart == 1 && !addrBad, "R2 start/address byte", nStart, 1);
      check(nStop == 1, "R6 single stop", nStop, 1);
      check(nWr == expWr, "R6 R8 write count", nWr, expWr);
      check(nRdAck == expRdAck, "R6 read ack count", nRdAck, expRdAck);
      check(nRdNack == expRdNack, "R6 read nack count", nRdNack, expRdNack);
      check(!byteBad, "R4 R5 data bytes", int'(byteBad), 0);
      check(!dropBad, "R4 R5 request drop", int'(dropBad), 0);
      check(!bothSeen, "R12 exclusive requests", int'(bothSeen), 0);
      check(lenErr == expLenErr, "R8 length error", int'(lenErr), int'(expLenErr));
      check(irqError == (expLenErr || an), "R8 R9 error flag",
            int'(irqError), int'(expLenErr || an));
      check(irqBusOwn == !an, "R9 R10 bus flag", int'(irqBusOwn), int'(!an));
      if (len == 0) check(nWr + nRdAck + nRdNack == 0, "R7 no data", nWr, 0);
    end

    // R11 sticky flags after an early NACK
    runTxn(1'b0, 1'b0, 3, 0);
    repeat (4) step();
    check(lenErr && irqError && irqBusOwn, "R11 sticky",
          int'({irqBusOwn, irqError, lenErr}), 7);
    flagClr = 1'b1; flagClrMask = 3'b010;
    step();
    check(!irqError && lenErr && irqBusOwn, "R11 clear error only",
          int'({irqBusOwn, irqError, lenErr}), 5);
    flagClr = 1'b1; flagClrMask = 3'b101;
    step();
    check(!irqError && !lenErr && !irqBusOwn, "R11 clear rest",
          int'({irqBusOwn, irqError, lenErr}), 0);

    // R2 address write with count-enable clear is ignored
    addrWr = 1'b1; addrLenEn = 1'b0; addrLen = 8'd2; addrRead = 1'b0;
    repeat (3) step();
    check(!busy && !engCmdValid, "R2 lenEn clear ignored", int'(busy), 0);

    // R3 smart enable gating
    smartEn = 1'b0;
    addrWr = 1'b1; addrLenEn = 1'b1; addrLen = 8'd1; addrRead = 1'b0;
    step();
    check(engCmdValid && engCmd == 3'd1, "R2 start offered", int'(engCmd), 1);
    engDone = 1'b1; engAck = 1'b1;
    repeat (3) step();
    check(busy && !dmaTxReq && !engCmdValid, "R3 tx masked", int'(dmaTxReq), 0);
    smartEn = 1'b1;
    #1;
    check(dmaTxReq, "R3 tx shown when enabled", int'(dmaTxReq), 1);
    dataWr = 1'b1; dataWrByte = 8'hC3;
    step();
    check(!dmaTxReq && engCmd == 3'd2 && engTxByte == 8'hC3, "R4 write byte",
          int'(engTxByte), 8'hC3);
    engDone = 1'b1; engAck = 1'b1;
    step();
    check(engCmd == 3'd5, "R6 stop after last write", int'(engCmd), 5);
    engDone = 1'b1;
    step();
    check(!busy, "R6 idle after stop", int'(busy), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule